// File: doc/BRIEF.md
# In-Group Store/Load Overlap Detector

This block tracks the stores committed within one dispatch group and flags any later load in that group whose byte range may collide with one of them. Each access is given as a base-pointer identifier, a signed byte offset from that base, and an access size in bytes. The block does not compare full addresses. Two accesses can only conflict when their base identifiers are equal, and then their offset ranges are compared.

A store commit is recorded at the clock edge. A load query is answered combinationally in the same cycle, so an issue stage can use the flag to insert a no-op instead of letting the load join the group. Up to four stores are held per group. Raising the group-end input, or reset, empties the record set.

Top module: `ovlpDetector`

## Requirements
- R1: At most four stores are recorded between clears. A store commit that arrives while four are already held is dropped and never causes a later load to be flagged.
- R2: A load whose base identifier and offset both equal those of a recorded store is flagged, whatever the two sizes are (including zero).
- R3: With equal bases and a recorded store offset strictly below the load offset, the load is flagged exactly when store offset plus store size is greater than the load offset.
- R4: With equal bases and a recorded store offset not below the load offset, the load is flagged exactly when load offset plus load size is greater than the store offset.
- R5: A recorded store with a base identifier different from the load's never causes a flag.
- R6: A store commit with `stHasMem` low is not recorded. A load with `ldHasMem` low, or with `ldValid` low, gives `overlap` = 0. With no store recorded, `overlap` is 0.
- R7: A cycle with `groupEnd` high clears every record at its clock edge, and a store committed in that same cycle is not recorded. Active-low reset `rstN` also clears every record.
- R8: Offsets are two's-complement 32-bit values and sizes are unsigned 8-bit values. End-of-range sums are formed in 33 bits, so a range that crosses the largest positive offset does not wrap around.
- R9: `overlap` reflects the load inputs in the same cycle. A store committed at a clock edge is visible to loads from the cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| groupEnd | input | 1 | Ends the dispatch group; clears all records |
| stValid | input | 1 | Store commit this cycle |
| stHasMem | input | 1 | Store carries memory-operand information |
| stBase | input | 8 | Store base-pointer identifier |
| stOffset | input | 32 | Store signed byte offset |
| stSize | input | 8 | Store size in bytes |
| ldValid | input | 1 | Load query this cycle |
| ldHasMem | input | 1 | Load carries memory-operand information |
| ldBase | input | 8 | Load base-pointer identifier |
| ldOffset | input | 32 | Load signed byte offset |
| ldSize | input | 8 | Load size in bytes |
| overlap | output | 1 | Load touches a recorded store's bytes |

## Verification
The bench probes ranges one byte on each side of every edge. A design that used greater-or-equal would flag a load that starts just past a store. A design that dropped the exact-match term would miss zero-size accesses at equal offsets. A fifth store is sent after four have been recorded, and then loaded from. A design without a capacity limit would flag that load, and one that overwrote a slot would lose an earlier match. Offsets near the positive limit show whether the end sum wraps, which would hide a real overlap. A store given in the same cycle as group end shows whether the clear wins, as required.

// File: rtl/ovlpPkg.sv
package ovlpPkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic clear;   // drop every record
    logic commit;  // write the selected slot
  } strobe_t;
endpackage

// File: rtl/ovlpCtrl.sv
module ovlpCtrl
  import ovlpPkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             groupEnd,
  input  logic             stValid,
  input  logic             stHasMem,
  output strobe_t          strobe,
  output logic [DEPTH-1:0] slotSel,
  output logic [CNT_W-1:0] recCount
);

  logic hasRoom;

  assign hasRoom       = recCount < CNT_W'(DEPTH);
  assign strobe.clear  = groupEnd;
  assign strobe.commit = stValid && stHasMem && !groupEnd && hasRoom;

  for (genvar i = 0; i < DEPTH; i++) begin : gSel
    assign slotSel[i] = (recCount == CNT_W'(i));
  end

  always_ff @(posedge clk) begin
    if (!rstN)              recCount <= '0;
    else if (strobe.clear)  recCount <= '0;
    else if (strobe.commit) recCount <= recCount + CNT_W'(1);
  end

endmodule

// File: rtl/ovlpDatapath.sv
module ovlpDatapath
  import ovlpPkg::*;
#(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned BASE_W = 8,
  parameter int unsigned OFF_W  = 32,
  parameter int unsigned SIZE_W = 8,
  localparam int unsigned EXT_W = OFF_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [DEPTH-1:0]  slotSel,
  input  logic [BASE_W-1:0] stBase,
  input  logic [OFF_W-1:0]  stOffset,
  input  logic [SIZE_W-1:0] stSize,
  input  logic              loadCheck,
  input  logic [BASE_W-1:0] ldBase,
  input  logic [OFF_W-1:0]  ldOffset,
  input  logic [SIZE_W-1:0] ldSize,
  output logic              overlap
);

  logic [DEPTH-1:0]  validR;
  logic [BASE_W-1:0] baseR [DEPTH];
  logic [OFF_W-1:0]  offR  [DEPTH];
  logic [SIZE_W-1:0] sizeR [DEPTH];

  logic signed [EXT_W-1:0] ldStart, ldEnd;
  logic signed [EXT_W-1:0] stStart [DEPTH];
  logic signed [EXT_W-1:0] stEnd   [DEPTH];
  logic [DEPTH-1:0] hitVec;

  // Sign-extend the offset by one bit; add the zero-extended size
  assign ldStart = {ldOffset[OFF_W-1], ldOffset};
  assign ldEnd   = ldStart + $signed({{(EXT_W-SIZE_W){1'b0}}, ldSize});

  for (genvar i = 0; i < DEPTH; i++) begin : gSlot
    logic baseEq, offEq, stLower, rangeHit;

    always_ff @(posedge clk) begin
      if (!rstN)             validR[i] <= 1'b0;
      else if (strobe.clear) validR[i] <= 1'b0;
      else if (strobe.commit && slotSel[i]) validR[i] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (strobe.commit && slotSel[i]) begin
        baseR[i] <= stBase;
        offR[i]  <= stOffset;
        sizeR[i] <= stSize;
      end
    end

    assign stStart[i] = {offR[i][OFF_W-1], offR[i]};
    assign stEnd[i]   = stStart[i] + $signed({{(EXT_W-SIZE_W){1'b0}}, sizeR[i]});

    assign baseEq   = (baseR[i] == ldBase);
    assign offEq    = (offR[i] == ldOffset);
    assign stLower  = stStart[i] < ldStart;
    assign rangeHit = stLower ? (stEnd[i] > ldStart) : (ldEnd > stStart[i]);
    assign hitVec[i] = validR[i] && baseEq && (offEq || rangeHit);
  end

  assign overlap = loadCheck && (|hitVec);

endmodule

// File: rtl/ovlpDetector.sv
module ovlpDetector
  import ovlpPkg::*;
#(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned BASE_W = 8,
  parameter int unsigned OFF_W  = 32,
  parameter int unsigned SIZE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              groupEnd,
  input  logic              stValid,
  input  logic              stHasMem,
  input  logic [BASE_W-1:0] stBase,
  input  logic [OFF_W-1:0]  stOffset,
  input  logic [SIZE_W-1:0] stSize,
  input  logic              ldValid,
  input  logic              ldHasMem,
  input  logic [BASE_W-1:0] ldBase,
  input  logic [OFF_W-1:0]  ldOffset,
  input  logic [SIZE_W-1:0] ldSize,
  output logic              overlap
);

  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  strobe_t          strobe;
  logic [DEPTH-1:0] slotSel;
  logic [CNT_W-1:0] recCount;
  logic             loadCheck;

  assign loadCheck = ldValid && ldHasMem && (recCount != '0);

  ovlpCtrl #(.DEPTH(DEPTH)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .groupEnd (groupEnd),
    .stValid  (stValid),
    .stHasMem (stHasMem),
    .strobe   (strobe),
    .slotSel  (slotSel),
    .recCount (recCount)
  );

  ovlpDatapath #(
    .DEPTH (DEPTH), .BASE_W(BASE_W), .OFF_W(OFF_W), .SIZE_W(SIZE_W)
  ) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .slotSel   (slotSel),
    .stBase    (stBase),
    .stOffset  (stOffset),
    .stSize    (stSize),
    .loadCheck (loadCheck),
    .ldBase    (ldBase),
    .ldOffset  (ldOffset),
    .ldSize    (ldSize),
    .overlap   (overlap)
  );

endmodule

// File: rtl/ovlpChecker.sv
module ovlpChecker #(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned BASE_W = 8,
  parameter int unsigned OFF_W  = 32,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              groupEnd,
  input logic              stValid,
  input logic              stHasMem,
  input logic [BASE_W-1:0] stBase,
  input logic [OFF_W-1:0]  stOffset,
  input logic              ldValid,
  input logic              ldHasMem,
  input logic [BASE_W-1:0] ldBase,
  input logic [OFF_W-1:0]  ldOffset,
  input logic              overlap,
  input logic [CNT_W-1:0]  recCount
);

  // R1
  cap_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    recCount <= CNT_W'(DEPTH));

  // R1
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (recCount == CNT_W'(DEPTH) && !groupEnd) |=> recCount == CNT_W'(DEPTH));

  // R6
  no_mem_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ldValid || !ldHasMem) |-> !overlap);

  // R7
  group_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(groupEnd)) |-> !overlap);

  // R9
  store_visible_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stValid && stHasMem && !groupEnd && recCount < CNT_W'(DEPTH)) |=>
      (!(ldValid && ldHasMem && ldBase == $past(stBase)
         && ldOffset == $past(stOffset)) || overlap));

endmodule

bind ovlpDetector ovlpChecker #(
  .DEPTH(DEPTH), .BASE_W(BASE_W), .OFF_W(OFF_W)
) uChk (
  .clk(clk), .rstN(rstN), .groupEnd(groupEnd),
  .stValid(stValid), .stHasMem(stHasMem), .stBase(stBase), .stOffset(stOffset),
  .ldValid(ldValid), .ldHasMem(ldHasMem), .ldBase(ldBase), .ldOffset(ldOffset),
  .overlap(overlap), .recCount(recCount)
);

// File: tb/tb_ovlpDetector.sv
module tb_ovlpDetector;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        groupEnd = 1'b0;
  logic        stValid = 1'b0, stHasMem = 1'b0;
  logic [7:0]  stBase = '0, stSize = '0;
  logic [31:0] stOffset = '0;
  logic        ldValid = 1'b0, ldHasMem = 1'b0;
  logic [7:0]  ldBase = '0, ldSize = '0;
  logic [31:0] ldOffset = '0;
  logic        overlap;

  int checkCount = 0;
  int failCount = 0;
  int cycles = 0;
  bit expQ[$];
  string tagQ[$];

  always #4 clk = ~clk;  // 125 MHz

  ovlpDetector dut (
    .clk(clk), .rstN(rstN), .groupEnd(groupEnd),
    .stValid(stValid), .stHasMem(stHasMem), .stBase(stBase),
    .stOffset(stOffset), .stSize(stSize),
    .ldValid(ldValid), .ldHasMem(ldHasMem), .ldBase(ldBase),
    .ldOffset(ldOffset), .ldSize(ldSize), .overlap(overlap)
  );

  task automatic idleAll();
    groupEnd = 1'b0; stValid = 1'b0; stHasMem = 1'b0;
    ldValid = 1'b0; ldHasMem = 1'b0;
  endtask

  task automatic doStore(input logic [7:0] b, input logic [31:0] off,
                         input logic [7:0] sz, input logic mem, input logic endGrp);
    @(posedge clk); #1;
    idleAll();
    stValid = 1'b1; stHasMem = mem; stBase = b; stOffset = off; stSize = sz;
    groupEnd = endGrp;
  endtask

  task automatic doEnd();
    @(posedge clk); #1;
    idleAll();
    groupEnd = 1'b1;
  endtask

  task automatic doLoad(input logic [7:0] b, input logic [31:0] off,
                        input logic [7:0] sz, input logic vld, input logic mem,
                        input bit exp, input string tag);
    @(posedge clk); #1;
    idleAll();
    ldValid = vld; ldHasMem = mem; ldBase = b; ldOffset = off; ldSize = sz;
    expQ.push_back(exp);
    tagQ.push_back(tag);
  endtask

  // Monitor: compares at the falling edge, away from the active edge
  always @(negedge clk) begin
    while (expQ.size() > 0) begin
      bit e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      checkCount++;
      if (overlap !== e) begin
        failCount++;
        $display("FAIL %s: overlap=%b expected=%b", t, overlap, e);
      end
    end
  end

  task automatic finishRun();
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checkCount++;
      failCount++;
      $display("FAIL watchdog: cycles=%0d expected<=20000", cycles);
      finishRun();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R7 reset state: nothing recorded
    doLoad(8'd1, 32'd0, 8'd4, 1'b1, 1'b1, 1'b0, "R7 reset empty");

    doStore(8'd1, 32'd100, 8'd4, 1'b1, 1'b0);
    doLoad(8'd1, 32'd100, 8'd1, 1'b1, 1'b1, 1'b1, "R2/R9 exact next cycle");
    doLoad(8'd1, 32'd100, 8'd0, 1'b1, 1'b1, 1'b1, "R2 exact zero size");
    doLoad(8'd1, 32'd103, 8'd1, 1'b1, 1'b1, 1'b1, "R3 last byte");
    doLoad(8'd1, 32'd104, 8'd1, 1'b1, 1'b1, 1'b0, "R3 just past end");
    doLoad(8'd1, 32'd97,  8'd3, 1'b1, 1'b1, 1'b0, "R4 ends at store start");
    doLoad(8'd1, 32'd97,  8'd4, 1'b1, 1'b1, 1'b1, "R4 reaches store start");
    doLoad(8'd2, 32'd100, 8'd4, 1'b1, 1'b1, 1'b0, "R5 other base");
    doLoad(8'd1, 32'd100, 8'd4, 1'b1, 1'b0, 1'b0, "R6 load no mem info");
    doLoad(8'd1, 32'd100, 8'd4, 1'b0, 1'b1, 1'b0, "R6 load not valid");

    doEnd();
    doLoad(8'd1, 32'd100, 8'd4, 1'b1, 1'b1, 1'b0, "R7 group end clears");

    doStore(8'd3, 32'd0, 8'd8, 1'b0, 1'b0);
    doLoad(8'd3, 32'd0, 8'd8, 1'b1, 1'b1, 1'b0, "R6 store no mem info");

    // R1 capacity
    doStore(8'd4, 32'd0,  8'd4, 1'b1, 1'b0);
    doStore(8'd4, 32'd10, 8'd4, 1'b1, 1'b0);
    doStore(8'd4, 32'd20, 8'd4, 1'b1, 1'b0);
    doStore(8'd4, 32'd30, 8'd4, 1'b1, 1'b0);
    doStore(8'd4, 32'd40, 8'd4, 1'b1, 1'b0);
    doLoad(8'd4, 32'd0,  8'd1, 1'b1, 1'b1, 1'b1, "R1 first slot kept");
    doLoad(8'd4, 32'd30, 8'd1, 1'b1, 1'b1, 1'b1, "R1 fourth slot kept");
    doLoad(8'd4, 32'd40, 8'd1, 1'b1, 1'b1, 1'b0, "R1 fifth store dropped");
    doEnd();
    doStore(8'd4, 32'd40, 8'd4, 1'b1, 1'b0);
    doLoad(8'd4, 32'd41, 8'd1, 1'b1, 1'b1, 1'b1, "R1 room after clear");

    // R8 signed offsets and no wrap
    doEnd();
    doStore(8'd5, -32'sd8, 8'd8, 1'b1, 1'b0);
    doLoad(8'd5, -32'sd1, 8'd1, 1'b1, 1'b1, 1'b1, "R8 negative in range");
    doLoad(8'd5, 32'd0,   8'd1, 1'b1, 1'b1, 1'b0, "R8 negative end");
    doStore(8'd6, 32'h7FFF_FF80, 8'd255, 1'b1, 1'b0);
    doLoad(8'd6, 32'h7FFF_FFF0, 8'd1, 1'b1, 1'b1, 1'b1, "R8 store end no wrap");
    doLoad(8'd6, 32'h8000_0000, 8'd255, 1'b1, 1'b1, 1'b0, "R8 most negative load");

    // R7 clear beats same-cycle store
    doStore(8'd7, 32'd0, 8'd4, 1'b1, 1'b1);
    doLoad(8'd7, 32'd0, 8'd4, 1'b1, 1'b1, 1'b0, "R7 store with group end dropped");
    doLoad(8'd6, 32'h7FFF_FFF0, 8'd1, 1'b1, 1'b1, 1'b0, "R7 old record cleared");

    @(posedge clk); #1 idleAll();
    @(posedge clk);
    @(negedge clk);
    finishRun();
  end
endmodule